// File: doc/BRIEF.md
# Processor Event Trace Buffer

This block is an on-chip debug recorder placed beside a small RISC core. Rather than sampling a wide signal bus every clock, it records only sparse events: each register-file write (destination index and the value written) and each taken branch (the program counter of the branch). Every event becomes one tagged record in an internal dual-port memory. The capture side writes one port in the core clock domain. The other port serves a simple indexed read that a host or testbench uses to dump the history once capture has stopped.

The memory is circular, so once full the newest record replaces the oldest. A stop condition comes either from an external trigger pin or from an optional comparator that fires when the core's current program counter equals a programmed value. After the stop condition, the block stores a programmable number of further records and then freezes, raising a done flag. The readout is in age order and reports how many records are valid.

Top module: `evtrace_buf`

## Requirements
- R1: After reset, `valid_count` is 0 and `triggered` and `done` are 0.
- R2: A register-file write is stored as a record whose tag `rd_tag` is 0 and whose payload holds the written value in bits [DATA_W-1:0] and the destination index directly above it, in bits [DATA_W+RADDR_W-1:DATA_W].
- R3: A taken branch is stored as a record whose tag is 1 and whose payload holds the branch program counter in bits [PC_W-1:0], with all higher payload bits zero.
- R4: When a register write and a taken branch happen in the same cycle, the register record takes the current slot at that clock edge and the branch record takes the next slot one clock later, so `valid_count` rises by one on each of the two edges.
- R5: A stop condition is `trig_in` high, or `match_en` high with `cur_pc` equal to `match_pc`. `triggered` is 1 from the clock edge after the first stop condition. With `match_en` low, equal program counters have no effect.
- R6: Records written in the edge of the stop condition are kept but not counted. Exactly `post_count` further records are then stored, and `done` is 1 from the edge that stores the last of them (or from the stop edge itself when `post_count` is 0). No record is stored while `done` is 1.
- R7: Storage is circular over DEPTH slots. After more than DEPTH records, `valid_count` stays at DEPTH and the oldest records are replaced.
- R8: Setting `rd_idx` to k presents, on `rd_tag` and `rd_payload` after the next clock edge, the k-th oldest valid record (k = 0 is the oldest).
- R9: Before the memory wraps, `valid_count` equals the number of records stored since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we | input | 1 | Register-file write strobe |
| rf_waddr | input | RADDR_W | Destination register index |
| rf_wdata | input | DATA_W | Value written to the register file |
| br_taken | input | 1 | Taken-branch strobe |
| br_pc | input | PC_W | Program counter of the taken branch |
| cur_pc | input | PC_W | Current program counter for the match comparator |
| match_en | input | 1 | Enables the program-counter stop condition |
| match_pc | input | PC_W | Program-counter value that stops capture |
| trig_in | input | 1 | External stop condition |
| post_count | input | CNT_W | Records to store after the stop condition |
| rd_idx | input | PTR_W | Age index of the record to read (0 = oldest) |
| rd_tag | output | 1 | Record type: 0 register write, 1 branch |
| rd_payload | output | PAY_W | Record payload |
| valid_count | output | CNT_W | Number of valid records |
| triggered | output | 1 | Stop condition has occurred |
| done | output | 1 | Capture frozen |

## Verification
The checker takes for granted that a cycle carrying both a register write and a taken branch is followed by a cycle with no event, since the single holding register has room for only one deferred branch; it checks this on the inputs. The directed stimulus respects this by always putting an idle cycle after each dual event. `post_count` is assumed steady around the stop edge, and the bench changes it only while idle under reset.

// File: rtl/evtrace_pkg.sv
package evtrace_pkg;

   // Record type carried in the top bit of every stored entry.
   typedef enum logic {
      EVT_REGWR  = 1'b0,
      EVT_BRANCH = 1'b1
   } evt_tag_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/evt_dpram.sv
module evt_dpram #(
   parameter int WIDTH = 38,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   // Capture port
   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // Inspection port, registered output
   always_ff @(posedge clk) begin
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/evt_seq.sv
module evt_seq
   import evtrace_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int RADDR_W = 5,
   parameter int PC_W    = 32,
   parameter int PAY_W   = 37
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               rf_we,
   input  logic [RADDR_W-1:0] rf_waddr,
   input  logic [DATA_W-1:0]  rf_wdata,
   input  logic               br_taken,
   input  logic [PC_W-1:0]    br_pc,
   output logic               wr_en,
   output evt_tag_e           wr_tag,
   output logic [PAY_W-1:0]   wr_pay
);

   logic            hold_v;
   logic [PC_W-1:0] hold_pc;
   logic            defer_br;

   // A branch that shares its cycle with a register write is deferred by one slot.
   assign defer_br = enable && !hold_v && rf_we && br_taken;

   always_comb begin
      wr_en  = 1'b0;
      wr_tag = EVT_REGWR;
      wr_pay = '0;
      if (enable) begin
         if (hold_v) begin
            wr_en  = 1'b1;
            wr_tag = EVT_BRANCH;
            wr_pay = PAY_W'(hold_pc);
         end else if (rf_we) begin
            wr_en  = 1'b1;
            wr_tag = EVT_REGWR;
            wr_pay = PAY_W'({rf_waddr, rf_wdata});
         end else if (br_taken) begin
            wr_en  = 1'b1;
            wr_tag = EVT_BRANCH;
            wr_pay = PAY_W'(br_pc);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_pc <= '0;
      end else begin
         hold_v <= defer_br;
         if (defer_br) begin
            hold_pc <= br_pc;
         end
      end
   end

endmodule

// File: rtl/evt_stop_ctl.sv
module evt_stop_ctl #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_hit,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] post_count,
   output logic             triggered,
   output logic             done
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         triggered <= 1'b0;
         done      <= 1'b0;
         remain    <= '0;
      end else if (!triggered) begin
         if (stop_hit) begin
            triggered <= 1'b1;
            remain    <= post_count;
            if (post_count == '0) begin
               done <= 1'b1;
            end
         end
      end else if (!done && wr_en) begin
         remain <= remain - 1'b1;
         if (remain == CNT_W'(1)) begin
            done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/evtrace_buf.sv
module evtrace_buf
   import evtrace_pkg::*;
#(
   parameter int  DEPTH        = 256,
   parameter int  DATA_W       = 32,
   parameter int  RADDR_W      = 5,
   parameter int  PC_W         = 32,
   parameter bit  HAS_PC_MATCH = 1'b1,
   localparam int PTR_W        = $clog2(DEPTH),
   localparam int CNT_W        = PTR_W + 1,
   localparam int PAY_W        = max_int(RADDR_W + DATA_W, PC_W),
   localparam int REC_W        = PAY_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rf_we,
   input  logic [RADDR_W-1:0] rf_waddr,
   input  logic [DATA_W-1:0]  rf_wdata,
   input  logic               br_taken,
   input  logic [PC_W-1:0]    br_pc,
   input  logic [PC_W-1:0]    cur_pc,
   input  logic               match_en,
   input  logic [PC_W-1:0]    match_pc,
   input  logic               trig_in,
   input  logic [CNT_W-1:0]   post_count,
   input  logic [PTR_W-1:0]   rd_idx,
   output logic               rd_tag,
   output logic [PAY_W-1:0]   rd_payload,
   output logic [CNT_W-1:0]   valid_count,
   output logic               triggered,
   output logic               done
);

   // Elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evtrace_buf: DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < 1 || RADDR_W < 1 || PC_W < 1) begin : g_bad_width
      $error("evtrace_buf: field widths must be positive");
   end

   logic             wr_en;
   evt_tag_e         wr_tag;
   logic [PAY_W-1:0] wr_pay;
   logic [PTR_W-1:0] wptr;
   logic             wrapped;
   logic [PTR_W-1:0] rd_base;
   logic [PTR_W-1:0] rd_addr;
   logic [REC_W-1:0] rd_rec;
   logic             pc_hit;
   logic             stop_hit;

   // Optional program-counter comparator
   if (HAS_PC_MATCH) begin : g_pc_match
      assign pc_hit = match_en && (cur_pc == match_pc);
   end else begin : g_no_pc_match
      assign pc_hit = 1'b0;
   end

   assign stop_hit = trig_in || pc_hit;

   evt_seq #(
      .DATA_W  (DATA_W),
      .RADDR_W (RADDR_W),
      .PC_W    (PC_W),
      .PAY_W   (PAY_W)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (!done),
      .rf_we    (rf_we),
      .rf_waddr (rf_waddr),
      .rf_wdata (rf_wdata),
      .br_taken (br_taken),
      .br_pc    (br_pc),
      .wr_en    (wr_en),
      .wr_tag   (wr_tag),
      .wr_pay   (wr_pay)
   );

   evt_stop_ctl #(
      .CNT_W (CNT_W)
   ) stop_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_hit   (stop_hit),
      .wr_en      (wr_en),
      .post_count (post_count),
      .triggered  (triggered),
      .done       (done)
   );

   // Circular write pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         wrapped <= 1'b0;
      end else if (wr_en) begin
         wptr <= wptr + 1'b1;
         if (wptr == PTR_W'(DEPTH - 1)) begin
            wrapped <= 1'b1;
         end
      end
   end

   assign valid_count = wrapped ? CNT_W'(DEPTH) : {1'b0, wptr};

   // Age-ordered read: oldest slot is the write pointer once wrapped
   assign rd_base = wrapped ? wptr : '0;
   assign rd_addr = rd_base + rd_idx;

   evt_dpram #(
      .WIDTH (REC_W),
      .DEPTH (DEPTH)
   ) ram_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wptr),
      .wr_data ({wr_tag, wr_pay}),
      .rd_addr (rd_addr),
      .rd_data (rd_rec)
   );

   assign rd_tag     = rd_rec[REC_W-1];
   assign rd_payload = rd_rec[PAY_W-1:0];

endmodule

// File: rtl/evtrace_buf_chk.sv
module evtrace_buf_chk #(
   parameter int DEPTH = 256,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rf_we,
   input logic             br_taken,
   input logic             trig_in,
   input logic             triggered,
   input logic             done,
   input logic [CNT_W-1:0] valid_count
);

   // R4 input rule: a dual-event cycle is followed by an idle cycle
   dual_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && br_taken) |=> !(rf_we || br_taken));

   // R9
   count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> valid_count >= $past(valid_count));

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_count <= CNT_W'(DEPTH));

   // R5
   trig_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_in |=> triggered);

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R6
   done_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(valid_count));

   // R6
   done_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> triggered);

endmodule

bind evtrace_buf evtrace_buf_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rf_we       (rf_we),
   .br_taken    (br_taken),
   .trig_in     (trig_in),
   .triggered   (triggered),
   .done        (done),
   .valid_count (valid_count)
);

// File: tb/evtrace_buf_tb.sv
module evtrace_buf_tb_top;

   localparam int DEPTH   = 256;
   localparam int DATA_W  = 32;
   localparam int RADDR_W = 5;
   localparam int PC_W    = 32;
   localparam int PTR_W   = 8;
   localparam int CNT_W   = 9;
   localparam int PAY_W   = 37;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               rf_we;
   logic [RADDR_W-1:0] rf_waddr;
   logic [DATA_W-1:0]  rf_wdata;
   logic               br_taken;
   logic [PC_W-1:0]    br_pc;
   logic [PC_W-1:0]    cur_pc;
   logic               match_en;
   logic [PC_W-1:0]    match_pc;
   logic               trig_in;
   logic [CNT_W-1:0]   post_count;
   logic [PTR_W-1:0]   rd_idx;
   logic               rd_tag;
   logic [PAY_W-1:0]   rd_payload;
   logic [CNT_W-1:0]   valid_count;
   logic               triggered;
   logic               done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   evtrace_buf dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rf_we       (rf_we),
      .rf_waddr    (rf_waddr),
      .rf_wdata    (rf_wdata),
      .br_taken    (br_taken),
      .br_pc       (br_pc),
      .cur_pc      (cur_pc),
      .match_en    (match_en),
      .match_pc    (match_pc),
      .trig_in     (trig_in),
      .post_count  (post_count),
      .rd_idx      (rd_idx),
      .rd_tag      (rd_tag),
      .rd_payload  (rd_payload),
      .valid_count (valid_count),
      .triggered   (triggered),
      .done        (done)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0;
      br_taken = 1'b0; br_pc = '0; trig_in = 1'b0;
   endtask

   task automatic do_reset(input logic [CNT_W-1:0] post);
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      cur_pc = '0; match_en = 1'b0; match_pc = 32'hFFFF_FFF0;
      post_count = post; rd_idx = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive one cycle of events, ending at the following negedge.
   task automatic cycle_ev(input logic we, input logic [RADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic bt, input logic [PC_W-1:0] pc);
      rf_we = we; rf_waddr = a; rf_wdata = d; br_taken = bt; br_pc = pc;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic pulse_trig();
      trig_in = 1'b1;
      @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic read_rec(input int k, output logic t, output logic [PAY_W-1:0] p);
      rd_idx = PTR_W'(k);
      @(negedge clk);
      t = rd_tag;
      p = rd_payload;
   endtask

   function automatic logic [63:0] reg_pay(input logic [RADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      return {27'b0, a, d};
   endfunction

   task automatic t_reset();
      do_reset(CNT_W'(0));
      check("R1 valid_count", 64'(valid_count), 64'd0);
      check("R1 triggered", 64'(triggered), 64'd0);
      check("R1 done", 64'(done), 64'd0);
   endtask

   task automatic t_regwrites();
      logic t; logic [PAY_W-1:0] p;
      do_reset(CNT_W'(0));
      cycle_ev(1'b1, 5'd3, 32'h1111_1111, 1'b0, '0);
      cycle_ev(1'b1, 5'd7, 32'h2222_2222, 1'b0, '0);
      cycle_ev(1'b1, 5'd31, 32'hDEAD_BEEF, 1'b0, '0);
      check("R9 count after 3 writes", 64'(valid_count), 64'd3);
      pulse_trig();
      read_rec(0, t, p);
      check("R2 tag0", 64'(t), 64'd0);
      check("R2 pay0", 64'(p), reg_pay(5'd3, 32'h1111_1111));
      read_rec(1, t, p);
      check("R8 pay1", 64'(p), reg_pay(5'd7, 32'h2222_2222));
      read_rec(2, t, p);
      check("R2 pay2", 64'(p), reg_pay(5'd31, 32'hDEAD_BEEF));
   endtask

   task automatic t_dual();
      logic t; logic [PAY_W-1:0] p;
      do_reset(CNT_W'(0));
      cycle_ev(1'b0, '0, '0, 1'b1, 32'h0000_0100);
      cycle_ev(1'b1, 5'd9, 32'h0000_0055, 1'b1, 32'h0000_2000);
      check("R4 count after dual edge", 64'(valid_count), 64'd2);
      @(negedge clk);
      check("R4 count one edge later", 64'(valid_count), 64'd3);
      cycle_ev(1'b1, 5'd10, 32'h0000_0066, 1'b0, '0);
      pulse_trig();
      read_rec(0, t, p);
      check("R3 tag branch", 64'(t), 64'd1);
      check("R3 pay branch", 64'(p), 64'h100);
      read_rec(1, t, p);
      check("R4 reg first tag", 64'(t), 64'd0);
      check("R4 reg first pay", 64'(p), reg_pay(5'd9, 32'h55));
      read_rec(2, t, p);
      check("R4 branch next tag", 64'(t), 64'd1);
      check("R4 branch next pay", 64'(p), 64'h2000);
      read_rec(3, t, p);
      check("R8 last pay", 64'(p), reg_pay(5'd10, 32'h66));
   endtask

   task automatic t_post();
      logic t; logic [PAY_W-1:0] p;
      do_reset(CNT_W'(2));
      cycle_ev(1'b1, 5'd1, 32'hA1, 1'b0, '0);
      pulse_trig();
      check("R5 triggered after trig_in", 64'(triggered), 64'd1);
      check("R6 not done yet", 64'(done), 64'd0);
      cycle_ev(1'b1, 5'd2, 32'hA2, 1'b0, '0);
      check("R6 not done after 1", 64'(done), 64'd0);
      cycle_ev(1'b0, '0, '0, 1'b1, 32'h0000_0300);
      check("R6 done after post_count", 64'(done), 64'd1);
      cycle_ev(1'b1, 5'd4, 32'hA4, 1'b0, '0);
      cycle_ev(1'b0, '0, '0, 1'b1, 32'h0000_0400);
      check("R6 no store after done", 64'(valid_count), 64'd3);
      read_rec(2, t, p);
      check("R6 last kept record", 64'(p), 64'h300);
   endtask

   task automatic t_wrap();
      logic t; logic [PAY_W-1:0] p;
      do_reset(CNT_W'(0));
      for (int i = 0; i < 300; i++) begin
         cycle_ev(1'b1, RADDR_W'(i), 32'hA000_0000 + DATA_W'(i), 1'b0, '0);
      end
      check("R7 count saturates", 64'(valid_count), 64'(DEPTH));
      pulse_trig();
      read_rec(0, t, p);
      check("R7 oldest after wrap", 64'(p), reg_pay(RADDR_W'(44), 32'hA000_0000 + 32'd44));
      read_rec(255, t, p);
      check("R8 newest after wrap", 64'(p), reg_pay(RADDR_W'(299), 32'hA000_0000 + 32'd299));
      read_rec(100, t, p);
      check("R8 middle after wrap", 64'(p), reg_pay(RADDR_W'(144), 32'hA000_0000 + 32'd144));
   endtask

   task automatic t_pcmatch();
      do_reset(CNT_W'(0));
      match_pc = 32'h0000_0400;
      cur_pc   = 32'h0000_0400;
      match_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R5 match disabled no trigger", 64'(triggered), 64'd0);
      cycle_ev(1'b1, 5'd5, 32'h77, 1'b0, '0);
      check("R5 still recording", 64'(valid_count), 64'd1);
      cur_pc = 32'h0000_03FC;
      match_en = 1'b1;
      @(negedge clk);
      check("R5 mismatch no trigger", 64'(triggered), 64'd0);
      cur_pc = 32'h0000_0400;
      @(negedge clk);
      cur_pc = 32'h0000_0404;
      check("R5 pc match triggers", 64'(triggered), 64'd1);
      check("R6 done with zero post", 64'(done), 64'd1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      cur_pc = '0; match_en = 1'b0; match_pc = '0; post_count = '0; rd_idx = '0;
      t_reset();
      t_regwrites();
      t_dual();
      t_post();
      t_wrap();
      t_pcmatch();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule